// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block drives a parallel bus whose address and data travel over one shared set of lines. A local requester hands it a cycle kind, a 22-bit byte address, a 16-bit write word and a block length. The master places the address on the shared lines and flags I/O-region accesses on a separate select line. It then raises a framing strobe that stays up for the whole cycle. Over the same lines it runs one or more data phases, each closed by a request/reply handshake with the addressed slave. The slave may take any time to reply.

Each strobe is held back for a programmed number of clocks after the lines it qualifies have settled, so a slave never has to de-skew anything. The asynchronous reply line is synchronised before use. Every handshake edge is guarded by a timeout: when it expires the cycle is abandoned and an error is reported. For each finished data phase the requester gets one `rsp_done` pulse, with the read result, the byte address of that phase and the error flag.

Top module: `mxbus_master`

## Requirements
- R1: Out of reset and whenever no cycle is active, `req_ready` is 1 and `bus_sync`, `bus_din`, `bus_dout`, `bus_dal_oe`, `bus_iosel`, `bus_byte` and `rsp_done` are 0.
- R2: A cycle starts with the request address driven on `bus_dal_out` with `bus_dal_oe` high for DESKEW clocks before `bus_sync` rises, and the address stays on the lines for DESKEW clocks after that.
- R3: `bus_iosel` is high during the address phase exactly when the request address is at or above IO_BASE (default 22'h3FE000), and is low during every data phase.
- R4: A word read (kind 0) raises `bus_din`; the 16-bit word returned by the slave appears on `rsp_rdata` with the `rsp_done` pulse of that phase.
- R5: A word write (kind 1) drives all 16 data bits on `bus_dal_out[15:0]` for DESKEW clocks before `bus_dout` rises and holds them unchanged while `bus_dout` is high; `rsp_rdata` is 0 on its done pulse.
- R6: A byte write (kind 2) raises `bus_byte` during the write phase and places `req_wdata[7:0]` on bits 7:0 when address bit 0 is 0, or on bits 15:8 when it is 1; the slave leaves the other byte of the word unchanged.
- R7: A read-modify-write (kind 3 word, kind 4 byte) runs a read phase and then a write phase at the same address inside one framing strobe, with a single done pulse; a byte read-modify-write returns the byte from the lane chosen by address bit 0 in `rsp_rdata[7:0]` with bits 15:8 zero, and writes `req_wdata[7:0]` into that lane.
- R8: `bus_din` and `bus_dout` are never high together and only while `bus_sync` is high; each strobe stays up until the reply is seen, and the next strobe waits until the reply has dropped, whatever the slave's reply delay.
- R9: For kinds 0, 1 and 2, `req_len` = N (N greater than 0) gives one address phase followed by N data phases at addresses that advance by 2, with one done pulse per phase carrying that phase's address on `rsp_addr`.
- R10: If the reply does not rise, or does not fall, within TIMEOUT clocks of the strobe edge, the master drops all strobes and `bus_sync` together, and emits a done pulse with `rsp_err` = 1, `rsp_rdata` = 0 and the failing phase's address; the remaining phases of a block are not run.
- R11: In a block write, the word for the next phase is taken from `req_wdata` as it stands during the clock in which the previous phase's `rsp_done` is high.
- R12: `req_len` = 0 runs a single data phase, kinds 5 to 7 run as a word read, and a read-modify-write always runs a single phase regardless of `req_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Master idle and able to take a request |
| req_kind | input | 3 | Cycle kind: 0 read, 1 write, 2 byte write, 3 word RMW, 4 byte RMW |
| req_addr | input | 22 | Byte address of the first data phase |
| req_wdata | input | 16 | Write data (byte kinds use bits 7:0) |
| req_len | input | 4 | Number of data phases for block kinds |
| rsp_done | output | 1 | One-clock pulse per completed data phase |
| rsp_err | output | 1 | Timeout flag, valid with `rsp_done` |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` |
| rsp_addr | output | 22 | Address of the completed phase |
| bus_dal_out | output | 22 | Shared address/data lines, outgoing value |
| bus_dal_oe | output | 1 | Master drives the shared lines |
| bus_dal_in | input | 16 | Shared data lines, value from the slave |
| bus_sync | output | 1 | Cycle framing strobe |
| bus_din | output | 1 | Read data strobe |
| bus_dout | output | 1 | Write data strobe |
| bus_byte | output | 1 | Byte write marker during a write phase |
| bus_iosel | output | 1 | I/O region select during the address phase |
| bus_rply | input | 1 | Asynchronous slave reply |

## Verification
The end of one block-write phase and the pickup of the next write word fall in the same clock: the done pulse is up during the one cycle in which the master samples `req_wdata` for the following phase. The bench provokes this with block writes of distinct words, changing `req_wdata` only at the moment it sees each done pulse. It judges the result by reading the block back, so a master that samples one clock early or late leaves a repeated or shifted word in the slave's memory. A second overlap, a read reply closing a read-modify-write read half while the write half is being set up, is judged the same way by the word and byte values read back afterwards.

// File: rtl/mxbus_pkg.sv
// Shared constants and types for the multiplexed bus master.
// Assumes the request kind is a 3-bit code; codes above 4 are folded to a read.
package mxbus_pkg;

    localparam logic [2:0] K_RD   = 3'd0;
    localparam logic [2:0] K_WR   = 3'd1;
    localparam logic [2:0] K_WRB  = 3'd2;
    localparam logic [2:0] K_RMW  = 3'd3;
    localparam logic [2:0] K_RMWB = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FRAME,
        ST_SETUP,
        ST_WAIT,
        ST_RELEASE,
        ST_NEXT
    } state_e;

endpackage

// File: rtl/mxbus_sync.sv
// Multi-stage synchroniser for one asynchronous level.
// Assumes STAGES >= 2; output lags the input by STAGES clocks.
module mxbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/mxbus_timer.sv
// Load-and-count-down timer; expired is high once the count reaches zero.
// Assumes the load value is nonzero when a wait is meaningful.
module mxbus_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Reload on start, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= load;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/mxbus_lane.sv
// Byte-lane steering between a requester word and the two-byte data path.
// Assumes DATA_W is even; lane_hi is address bit 0.
module mxbus_lane #(
    parameter int DATA_W = 16
) (
    input  logic              byte_mode,
    input  logic              lane_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_word
);

    localparam int BW = DATA_W / 2;

    // Move the write byte into its lane, or pass the full word.
    always_comb begin
        if (!byte_mode)   bus_wdata = wdata;
        else if (lane_hi) bus_wdata = {wdata[BW-1:0], {BW{1'b0}}};
        else              bus_wdata = {{BW{1'b0}}, wdata[BW-1:0]};
    end

    // Pull the read byte down from its lane, or pass the full word.
    always_comb begin
        if (!byte_mode)   rd_word = bus_rdata;
        else if (lane_hi) rd_word = {{BW{1'b0}}, bus_rdata[DATA_W-1:BW]};
        else              rd_word = {{BW{1'b0}}, bus_rdata[BW-1:0]};
    end

endmodule

// File: rtl/mxbus_master.sv
// Bus master for a shared address/data bus: address phase with I/O select,
// then one or more handshaked data phases, with de-skew and timeout.
// Assumes DESKEW >= 1, TIMEOUT >= 1, ADDR_W > DATA_W, SYNC_STAGES >= 2.
module mxbus_master
    import mxbus_pkg::*;
#(
    parameter int              ADDR_W      = 22,
    parameter int              DATA_W      = 16,
    parameter int              LEN_W       = 4,
    parameter int              DESKEW      = 2,
    parameter int              TIMEOUT     = 64,
    parameter int              SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] IO_BASE   = 22'h3FE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LEN_W-1:0]  req_len,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [ADDR_W-1:0] bus_dal_out,
    output logic              bus_dal_oe,
    input  logic [DATA_W-1:0] bus_dal_in,
    output logic              bus_sync,
    output logic              bus_din,
    output logic              bus_dout,
    output logic              bus_byte,
    output logic              bus_iosel,
    input  logic              bus_rply
);

    localparam int DSK_W = $clog2(DESKEW + 1);
    localparam int TMO_W = $clog2(TIMEOUT + 1);
    localparam logic [DSK_W-1:0] DSK_LOAD = DSK_W'(DESKEW);
    localparam logic [TMO_W-1:0] TMO_LOAD = TMO_W'(TIMEOUT);
    localparam logic [LEN_W-1:0] ONE_LEN  = LEN_W'(1);
    localparam logic [ADDR_W-1:0] WSTEP   = ADDR_W'(2);

    state_e            state, state_d;
    logic [2:0]        kind_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rd_q;
    logic [LEN_W-1:0]  remain_q;
    logic              io_q;
    logic              wr_half_q;

    logic rply_s;
    logic dsk_start, dsk_exp;
    logic tmo_start, tmo_exp;
    logic ev_accept, ev_reply, ev_turn, ev_done, ev_timeout, ev_next;

    logic is_byte, is_rmw, is_readkind, phase_write;
    logic in_addr, in_data;
    logic [DATA_W-1:0] lane_w, lane_r;
    logic [2:0] kind_norm;

    // Decode the latched kind into the controls the phases need.
    always_comb begin
        is_byte     = (kind_q == K_WRB) || (kind_q == K_RMWB);
        is_rmw      = (kind_q == K_RMW) || (kind_q == K_RMWB);
        is_readkind = (kind_q == K_RD) || is_rmw;
        phase_write = (kind_q == K_WR) || (kind_q == K_WRB) || (is_rmw && wr_half_q);
        kind_norm   = (req_kind > K_RMWB) ? K_RD : req_kind;
    end

    mxbus_sync #(.STAGES(SYNC_STAGES)) i_rply_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_rply),
        .q     (rply_s)
    );

    mxbus_timer #(.W(DSK_W)) i_deskew (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (dsk_start),
        .load    (DSK_LOAD),
        .expired (dsk_exp)
    );

    mxbus_timer #(.W(TMO_W)) i_timeout (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmo_start),
        .load    (TMO_LOAD),
        .expired (tmo_exp)
    );

    mxbus_lane #(.DATA_W(DATA_W)) i_lane (
        .byte_mode (is_byte),
        .lane_hi   (addr_q[0]),
        .wdata     (wdata_q),
        .bus_rdata (bus_dal_in),
        .bus_wdata (lane_w),
        .rd_word   (lane_r)
    );

    // Next-state logic, timer restarts and the events that update registers.
    always_comb begin
        state_d    = state;
        dsk_start  = 1'b0;
        tmo_start  = 1'b0;
        ev_accept  = 1'b0;
        ev_reply   = 1'b0;
        ev_turn    = 1'b0;
        ev_done    = 1'b0;
        ev_timeout = 1'b0;
        ev_next    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d   = ST_ADDR;
                    dsk_start = 1'b1;
                    ev_accept = 1'b1;
                end
            end
            ST_ADDR: begin
                if (dsk_exp) begin
                    state_d   = ST_FRAME;
                    dsk_start = 1'b1;
                end
            end
            ST_FRAME: begin
                if (dsk_exp) begin
                    state_d   = ST_SETUP;
                    dsk_start = 1'b1;
                end
            end
            ST_SETUP: begin
                if (dsk_exp && !rply_s) begin
                    state_d   = ST_WAIT;
                    tmo_start = 1'b1;
                end
            end
            ST_WAIT: begin
                if (rply_s) begin
                    state_d   = ST_RELEASE;
                    tmo_start = 1'b1;
                    ev_reply  = 1'b1;
                end else if (tmo_exp) begin
                    state_d    = ST_IDLE;
                    ev_timeout = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!rply_s) begin
                    if (is_rmw && !wr_half_q) begin
                        state_d   = ST_SETUP;
                        dsk_start = 1'b1;
                        ev_turn   = 1'b1;
                    end else begin
                        ev_done = 1'b1;
                        state_d = (remain_q > ONE_LEN) ? ST_NEXT : ST_IDLE;
                    end
                end else if (tmo_exp) begin
                    state_d    = ST_IDLE;
                    ev_timeout = 1'b1;
                end
            end
            ST_NEXT: begin
                state_d   = ST_SETUP;
                dsk_start = 1'b1;
                ev_next   = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Request capture, per-phase address/data advance and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= K_RD;
            addr_q    <= '0;
            wdata_q   <= '0;
            rd_q      <= '0;
            remain_q  <= '0;
            io_q      <= 1'b0;
            wr_half_q <= 1'b0;
        end else begin
            if (ev_accept) begin
                kind_q    <= kind_norm;
                addr_q    <= req_addr;
                wdata_q   <= req_wdata;
                io_q      <= (req_addr >= IO_BASE);
                wr_half_q <= 1'b0;
                if (kind_norm == K_RMW || kind_norm == K_RMWB || req_len == '0)
                    remain_q <= ONE_LEN;
                else
                    remain_q <= req_len;
            end
            if (ev_reply && !phase_write) rd_q <= lane_r;
            if (ev_turn)  wr_half_q <= 1'b1;
            if (ev_done)  remain_q  <= remain_q - 1'b1;
            if (ev_next) begin
                addr_q  <= addr_q + WSTEP;
                wdata_q <= req_wdata;
            end
        end
    end

    // Response pulse with result, address and error for each finished phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            rsp_addr  <= '0;
        end else begin
            rsp_done <= ev_done || ev_timeout;
            rsp_err  <= ev_timeout;
            if (ev_done) begin
                rsp_rdata <= is_readkind ? rd_q : '0;
                rsp_addr  <= addr_q;
            end else if (ev_timeout) begin
                rsp_rdata <= '0;
                rsp_addr  <= addr_q;
            end
        end
    end

    // Phase decode for the bus outputs.
    always_comb begin
        in_addr = (state == ST_ADDR) || (state == ST_FRAME);
        in_data = (state == ST_SETUP) || (state == ST_WAIT) || (state == ST_RELEASE);
    end

    // Drive the shared lines and strobes from the current phase.
    always_comb begin
        req_ready  = (state == ST_IDLE);
        bus_sync   = (state != ST_IDLE) && (state != ST_ADDR);
        bus_iosel  = in_addr && io_q;
        bus_dal_oe = in_addr || (in_data && phase_write);
        bus_din    = (state == ST_WAIT) && !phase_write;
        bus_dout   = (state == ST_WAIT) && phase_write;
        bus_byte   = in_data && phase_write && is_byte;
        if (in_addr)
            bus_dal_out = addr_q;
        else if (in_data && phase_write)
            bus_dal_out = {{(ADDR_W-DATA_W){1'b0}}, lane_w};
        else
            bus_dal_out = '0;
    end

endmodule

// File: rtl/mxbus_master_chk.sv
// Protocol checker for the bus master, attached by bind.
// Assumes the master's port names; all checks are off during reset.
module mxbus_master_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] bus_dal_out,
    input logic              bus_dal_oe,
    input logic              bus_sync,
    input logic              bus_din,
    input logic              bus_dout,
    input logic              bus_byte,
    input logic              bus_iosel
);

    // R8: the two data strobes never overlap.
    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_din && bus_dout));

    // R8: data strobes only inside the framing strobe.
    assert_strobe_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_din || bus_dout) |-> bus_sync);

    // R2: address already settled and driven when the framing strobe rises.
    assert_addr_deskew_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_sync) |-> ($stable(bus_dal_out) && bus_dal_oe));

    // R5: write data settled and driven when the write strobe rises.
    assert_wdata_deskew_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_dout) |-> ($stable(bus_dal_out) && bus_dal_oe));

    // R5: write data held while the write strobe is up.
    assert_wdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dout && $past(bus_dout)) |-> $stable(bus_dal_out));

    // R10: an error flag only comes with a done pulse.
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_done);

    // R10: on a timeout the bus is already released.
    assert_err_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (!bus_sync && !bus_din && !bus_dout));

    // R1: an idle master leaves the bus alone.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_sync && !bus_dal_oe && !bus_iosel));

    // R3: the I/O select belongs to the address phase only.
    assert_iosel_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iosel |-> (bus_dal_oe && !bus_din && !bus_dout));

    // R6: the byte marker never accompanies a read strobe.
    assert_byte_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_byte |-> !bus_din);

endmodule

bind mxbus_master mxbus_master_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_err     (rsp_err),
    .bus_dal_out (bus_dal_out),
    .bus_dal_oe  (bus_dal_oe),
    .bus_sync    (bus_sync),
    .bus_din     (bus_din),
    .bus_dout    (bus_dout),
    .bus_byte    (bus_byte),
    .bus_iosel   (bus_iosel)
);

// File: tb/test_mxbus_master.sv
// Scoreboard bench: the driver pushes expected responses, a monitor pops them
// on each done pulse, and a behavioural slave serves the bus.
module test_mxbus_master;

    localparam int CLK_P = 10;
    localparam logic [21:0] IO_BASE = 22'h3FE000;

    typedef struct packed {
        logic        err;
        logic [15:0] rd;
        logic [21:0] ad;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = 3'd0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  req_len = '0;
    logic        rsp_done, rsp_err;
    logic [15:0] rsp_rdata;
    logic [21:0] rsp_addr;
    logic [21:0] bus_dal_out;
    logic        bus_dal_oe;
    logic [15:0] bus_dal_in = '0;
    logic        bus_sync, bus_din, bus_dout, bus_byte, bus_iosel;
    logic        bus_rply = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    exp_t  expq[$];
    string tagq[$];

    logic [15:0] smem [0:63];
    logic [15:0] rmem [0:63];
    bit          slave_mute = 1'b0;
    int          slave_delay = 0;
    logic [21:0] s_first_addr;
    logic        s_io;
    int          s_syncs = 0;

    mxbus_master i_mxbus_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
        .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .rsp_addr(rsp_addr),
        .bus_dal_out(bus_dal_out), .bus_dal_oe(bus_dal_oe), .bus_dal_in(bus_dal_in),
        .bus_sync(bus_sync), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_byte(bus_byte), .bus_iosel(bus_iosel), .bus_rply(bus_rply)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural slave: latches the address at the framing edge, tracks
    // consecutive addresses and answers each strobe after slave_delay clocks.
    initial begin
        logic [21:0] cur;
        logic [5:0]  i;
        bit          have_prev, prev_din;
        forever begin
            @(negedge clk);
            if (bus_sync) begin
                s_first_addr = bus_dal_out;
                s_io         = bus_iosel;
                s_syncs++;
                cur       = bus_dal_out;
                have_prev = 1'b0;
                prev_din  = 1'b0;
                while (bus_sync) begin
                    if (bus_din || bus_dout) begin
                        if (have_prev && !(prev_din && bus_dout)) cur = cur + 22'd2;
                        have_prev = 1'b1;
                        prev_din  = bus_din;
                        if (slave_mute) begin
                            while (bus_sync) @(negedge clk);
                        end else begin
                            repeat (slave_delay) @(negedge clk);
                            i = cur[6:1];
                            if (bus_din) bus_dal_in = smem[i];
                            else if (bus_byte) begin
                                if (cur[0]) smem[i][15:8] = bus_dal_out[15:8];
                                else        smem[i][7:0]  = bus_dal_out[7:0];
                            end else smem[i] = bus_dal_out[15:0];
                            bus_rply = 1'b1;
                            while (bus_din || bus_dout) @(negedge clk);
                            bus_rply = 1'b0;
                        end
                    end
                    if (bus_sync) @(negedge clk);
                end
            end
        end
    end

    // Monitor: compare every done pulse with the oldest expected item.
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(negedge clk);
            if (rst_n && rsp_done) begin
                if (expq.size() == 0) begin
                    check(1'b0, "unexpected done", 64'(rsp_addr), 64'(0));
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check({rsp_err, rsp_rdata, rsp_addr} == e, t,
                          64'({rsp_err, rsp_rdata, rsp_addr}), 64'(e));
                    if (rsp_err)
                        check(!bus_sync && !bus_din && !bus_dout, "R10 bus release",
                              64'({bus_sync, bus_din, bus_dout}), 64'(0));
                end
            end
        end
    end

    // Driver: compute expectations from the requirements, then run the request.
    task automatic run(input logic [2:0] kind, input logic [21:0] addr,
                       input logic [3:0] len, input logic [15:0] wbase, input string tag);
        int          n;
        int          syncs0;
        logic [21:0] a;
        logic [5:0]  ix;
        logic [15:0] w, old;
        logic [2:0]  k;
        k = (kind > 3'd4) ? 3'd0 : kind;
        n = (k == 3'd3 || k == 3'd4 || len == 0) ? 1 : int'(len);
        if (slave_mute) begin
            expq.push_back({1'b1, 16'h0, addr});
            tagq.push_back({tag, " timeout"});
        end else begin
            for (int j = 0; j < n; j++) begin
                a   = addr + 22'(2 * j);
                ix  = a[6:1];
                w   = wbase + 16'(j * 16'h0101);
                old = rmem[ix];
                case (k)
                    3'd0: expq.push_back({1'b0, old, a});
                    3'd1: begin rmem[ix] = w; expq.push_back({1'b0, 16'h0, a}); end
                    3'd2: begin
                        if (a[0]) rmem[ix][15:8] = w[7:0]; else rmem[ix][7:0] = w[7:0];
                        expq.push_back({1'b0, 16'h0, a});
                    end
                    3'd3: begin rmem[ix] = w; expq.push_back({1'b0, old, a}); end
                    default: begin
                        if (a[0]) begin
                            rmem[ix][15:8] = w[7:0];
                            expq.push_back({1'b0, {8'h0, old[15:8]}, a});
                        end else begin
                            rmem[ix][7:0] = w[7:0];
                            expq.push_back({1'b0, {8'h0, old[7:0]}, a});
                        end
                    end
                endcase
                tagq.push_back(tag);
            end
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        syncs0    = s_syncs;
        req_kind  = kind;
        req_addr  = addr;
        req_len   = len;
        req_wdata = wbase;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!slave_mute && (k == 3'd1 || k == 3'd2)) begin
            for (int j = 1; j < n; j++) begin
                while (!rsp_done) @(negedge clk);
                req_wdata = wbase + 16'(j * 16'h0101);   // R11 next word in done cycle
                @(negedge clk);
            end
        end
        while (!(req_ready && expq.size() == 0)) @(negedge clk);
        check(s_first_addr == addr, "R2 address phase", 64'(s_first_addr), 64'(addr));
        check(s_io == (addr >= IO_BASE), "R3 io select", 64'(s_io), 64'(addr >= IO_BASE));
        check(s_syncs == syncs0 + 1, "R9 single address phase", 64'(s_syncs), 64'(syncs0 + 1));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            smem[i] = 16'hA000 + 16'(i * 37);
            rmem[i] = 16'hA000 + 16'(i * 37);
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready && !bus_sync && !bus_din && !bus_dout && !bus_dal_oe &&
              !bus_iosel && !bus_byte && !rsp_done, "R1 reset state",
              64'({req_ready, bus_sync, bus_din, bus_dout, bus_dal_oe, bus_iosel, bus_byte, rsp_done}),
              64'(8'h80));
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !bus_sync, "R1 idle after reset", 64'({req_ready, bus_sync}), 64'(2'b10));

        slave_delay = 1;
        run(3'd0, 22'h000004, 4'd1, 16'h0, "R4 word read");
        run(3'd1, 22'h000010, 4'd1, 16'h1234, "R5 word write");
        run(3'd0, 22'h000010, 4'd1, 16'h0, "R5 readback");
        run(3'd2, 22'h000012, 4'd1, 16'h00C5, "R6 byte write low lane");
        run(3'd2, 22'h000015, 4'd1, 16'h005E, "R6 byte write high lane");
        run(3'd0, 22'h000012, 4'd1, 16'h0, "R6 readback low");
        run(3'd0, 22'h000014, 4'd1, 16'h0, "R6 readback high");
        run(3'd3, 22'h000018, 4'd3, 16'hBEEF, "R7 word rmw");
        run(3'd4, 22'h00001B, 4'd1, 16'h0077, "R7 byte rmw odd");
        run(3'd4, 22'h00001C, 4'd1, 16'h0033, "R7 byte rmw even");
        run(3'd0, 22'h000018, 4'd2, 16'h0, "R7 readback");
        run(3'd0, 22'h000020, 4'd4, 16'h0, "R9 block read");
        run(3'd1, 22'h000040, 4'd3, 16'h1111, "R11 block write");
        run(3'd0, 22'h000040, 4'd3, 16'h0, "R11 block readback");
        run(3'd2, 22'h000051, 4'd2, 16'h0042, "R9 block byte write");
        run(3'd0, 22'h000050, 4'd2, 16'h0, "R9 block byte readback");
        run(3'd0, 22'h3FE010, 4'd1, 16'h0, "R3 io read");
        run(3'd1, 22'h3FDFFE, 4'd1, 16'h5A5A, "R3 below io base");
        run(3'd7, 22'h000030, 4'd0, 16'h0, "R12 kind7 len0 read");
        run(3'd1, 22'h000032, 4'd0, 16'h9999, "R12 len0 write");
        run(3'd0, 22'h000032, 4'd1, 16'h0, "R12 readback");
        for (int d = 0; d < 7; d++) begin
            slave_delay = d;
            run(3'd0, 22'(22'h000060 + 2 * d), 4'd2, 16'h0, "R8 reply delay read");
            run(3'd3, 22'(22'h000070 + 2 * d), 4'd1, 16'(16'h4400 + d), "R8 reply delay rmw");
        end
        slave_delay = 2;
        slave_mute = 1'b1;
        run(3'd0, 22'h000024, 4'd3, 16'h0, "R10 read block");
        run(3'd1, 22'h000026, 4'd1, 16'hDEAD, "R10 write");
        slave_mute = 1'b0;
        run(3'd0, 22'h000024, 4'd2, 16'h0, "R10 recovery readback");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule